// File: doc/BRIEF.md
# Random Bitstream Health Monitor

This block checks the quality of a random source while it runs. It takes the raw serial bits of the source, one bit per transfer, and the 32-bit words assembled from them, one word per transfer. It reports failures as single-cycle event pulses on an eight-bit event vector. The bit positions of that vector match the positions a status register uses, so the vector can be OR-ed straight into sticky status bits further up.

Four tests run side by side:
- A ones count over fixed windows of 20,000 bits.
- A run-length detector that fires at 34 identical consecutive bits.
- A second run-length threshold that fires at 48 identical bits, which points to a dead noise source.
- A comparator that flags two equal output words in a row.

Both inputs are valid/ready streams. The monitor applies no back-pressure while it is enabled: each ready output follows the enable input. While enable is high, every cycle with valid high is a transfer. While enable is low, ready is low, no transfer happens, and all test state is cleared. A producer that holds valid high while ready is low loses nothing, because no transfer is counted until ready returns.

Top module: `bitstream_health_mon`

## Requirements
- R1: After reset the event vector is all zero. Each ready output is high exactly when the enable input is high.
- R2: Bits accepted since enable are grouped into windows of 20,000. Bit 7 of the event vector pulses on the cycle after the last bit of a window if the window held at most 9,654 or at least 10,346 ones. It stays low if the count lies strictly between those two values.
- R3: After each window the ones count and the bit position restart, so consecutive windows are judged independently.
- R4: Bit 5 of the event vector pulses on the cycle after the 34th identical consecutive bit. It pulses once per run, however long the run becomes.
- R5: Bit 3 of the event vector pulses on the cycle after the 48th identical consecutive bit. It pulses once per run.
- R6: A bit that differs from the previous accepted bit restarts the run length at 1.
- R7: Bit 2 of the event vector pulses on the cycle after an accepted word equal to the word accepted just before it.
- R8: The first word accepted after reset, or after enable rises, is never compared with an earlier word.
- R9: Cycles without an accepted bit leave the window count and the run length unchanged, and raise no bit event.
- R10: Event bits 7, 5 and 3 are single-cycle pulses. Bits 6, 4, 1 and 0 are always zero.
- R11: While enable is low, no event fires and every test's state is cleared. A run or window in progress before the enable went low does not carry over after enable returns high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Monitor enable; low clears all test state |
| bit_valid | input | 1 | Raw bit offered |
| bit_ready | output | 1 | Raw bit accepted (follows en) |
| bit_data | input | 1 | Raw random bit |
| word_valid | input | 1 | Output word offered |
| word_ready | output | 1 | Output word accepted (follows en) |
| word_data | input | 32 | Assembled output word |
| health_evt | output | 8 | Event pulses: 7 ones count, 5 long run, 3 noise run, 2 repeated word |

## Verification
Every event is registered once. It is therefore visible for exactly the one cycle that follows the rising edge that accepted the triggering bit or word. The bench drives each transfer at a falling edge and samples the event vector at the next falling edge. Each observed pulse is thus tied to the transfer that caused it, and the bench records the index of that transfer. The window tests place the ones-count verdict on the 20,000th bit. The run tests check that the 34th and 48th bits of a run are the ones that produce the pulses.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int EVT_W     = 8;
  localparam int EVT_MONO  = 7;
  localparam int EVT_LRUN  = 5;
  localparam int EVT_NOISE = 3;
  localparam int EVT_STUCK = 2;
  localparam logic [EVT_W-1:0] EVT_USED =
    (8'd1 << EVT_MONO) | (8'd1 << EVT_LRUN) | (8'd1 << EVT_NOISE) | (8'd1 << EVT_STUCK);
  typedef logic [EVT_W-1:0] evt_t;
endpackage

// File: rtl/hm_monobit.sv
module hm_monobit #(
  parameter int WIN = 20000,
  parameter int LO  = 9654,
  parameter int HI  = 10346
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic take,
  input  logic bit_in,
  output logic fail
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LAST_IDX = CW'(WIN - 1);
  localparam logic [CW-1:0] LO_C     = CW'(LO);
  localparam logic [CW-1:0] HI_C     = CW'(HI);

  logic [CW-1:0] idx_q, ones_q, ones_n;
  logic          at_end;

  always_comb begin
    ones_n = ones_q + CW'(bit_in);
    at_end = (idx_q == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      idx_q  <= '0;
      ones_q <= '0;
      fail   <= 1'b0;
    end else begin
      fail <= 1'b0;
      if (take) begin
        if (at_end) begin
          fail   <= (ones_n <= LO_C) || (ones_n >= HI_C);
          idx_q  <= '0;
          ones_q <= '0;
        end else begin
          idx_q  <= idx_q + 1'b1;
          ones_q <= ones_n;
        end
      end
    end
  end
endmodule

// File: rtl/hm_runlen.sv
module hm_runlen #(
  parameter int NTHR = 2,
  parameter int THR [NTHR] = '{34, 48},
  parameter int CAP  = 49
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            take,
  input  logic            bit_in,
  output logic [NTHR-1:0] hit
);
  localparam int LW = $clog2(CAP + 1);
  localparam logic [LW-1:0] CAP_C = LW'(CAP);

  logic          prev_q, have_q;
  logic [LW-1:0] len_q, len_n;

  always_comb begin
    if (have_q && (bit_in == prev_q))
      len_n = (len_q == CAP_C) ? CAP_C : len_q + 1'b1;
    else
      len_n = LW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      prev_q <= 1'b0;
      have_q <= 1'b0;
      len_q  <= '0;
    end else if (take) begin
      prev_q <= bit_in;
      have_q <= 1'b1;
      len_q  <= len_n;
    end
  end

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    localparam logic [LW-1:0] T_C = LW'(THR[g]);
    always_ff @(posedge clk) begin
      if (!rst_n || clr) hit[g] <= 1'b0;
      else               hit[g] <= take && (len_n == T_C) && (len_q != T_C);
    end
  end
endmodule

// File: rtl/hm_stuck.sv
module hm_stuck #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         take,
  input  logic [W-1:0] word_in,
  output logic         hit
);
  logic [W-1:0] last_q;
  logic         seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      last_q <= '0;
      seen_q <= 1'b0;
      hit    <= 1'b0;
    end else begin
      hit <= take && seen_q && (word_in == last_q);
      if (take) begin
        last_q <= word_in;
        seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bitstream_health_mon.sv
module bitstream_health_mon
  import hm_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int WIN       = 20000,
  parameter int ONES_LO   = 9654,
  parameter int ONES_HI   = 10346,
  parameter int LONG_RUN  = 34,
  parameter int NOISE_RUN = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              bit_valid,
  output logic              bit_ready,
  input  logic              bit_data,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic [EVT_W-1:0]  health_evt
);
  localparam int RUN_CAP = ((NOISE_RUN > LONG_RUN) ? NOISE_RUN : LONG_RUN) + 1;
  localparam int NTHR = 2;

  logic            take_bit, take_word, clr;
  logic            mono_fail, stuck_hit;
  logic [NTHR-1:0] run_hit;

  assign bit_ready  = en;
  assign word_ready = en;
  assign take_bit   = bit_valid && en;
  assign take_word  = word_valid && en;
  assign clr        = !en;

  hm_monobit #(.WIN(WIN), .LO(ONES_LO), .HI(ONES_HI)) u_mono (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take_bit),
    .bit_in(bit_data), .fail(mono_fail)
  );

  hm_runlen #(.NTHR(NTHR), .THR('{LONG_RUN, NOISE_RUN}), .CAP(RUN_CAP)) u_run (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take_bit),
    .bit_in(bit_data), .hit(run_hit)
  );

  hm_stuck #(.W(WORD_W)) u_stuck (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take_word),
    .word_in(word_data), .hit(stuck_hit)
  );

  always_comb begin
    health_evt            = '0;
    health_evt[EVT_MONO]  = mono_fail;
    health_evt[EVT_LRUN]  = run_hit[0];
    health_evt[EVT_NOISE] = run_hit[1];
    health_evt[EVT_STUCK] = stuck_hit;
  end
endmodule

// File: rtl/bitstream_health_mon_chk.sv
module bitstream_health_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       bit_valid,
  input logic       word_valid,
  input logic [7:0] health_evt
);
  // R9: no accepted bit, no bit event on the next cycle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && en) |=> (health_evt[7] == 1'b0 && health_evt[5] == 1'b0 && health_evt[3] == 1'b0));
  // R7: a repeated-word event needs a word accepted on the cycle before
  p_stuck_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    health_evt[2] |-> $past(word_valid && en));
  // R11: disabled monitor stays silent
  p_disabled_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (health_evt == 8'h00));
  // R2: ones-count verdict is a single pulse
  p_mono_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    health_evt[7] |=> !health_evt[7]);
  // R4: long-run event is a single pulse
  p_long_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    health_evt[5] |=> !health_evt[5]);
  // R5: noise event is a single pulse
  p_noise_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    health_evt[3] |=> !health_evt[3]);
  // R10: unused event bits stay low
  p_unused_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (health_evt & 8'h53) == 8'h00);
endmodule

bind bitstream_health_mon bitstream_health_mon_chk i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .bit_valid(bit_valid),
  .word_valid(word_valid), .health_evt(health_evt)
);

// File: tb/test_bitstream_health_mon.sv
module test_bitstream_health_mon;
  localparam int WIN = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_data = 1'b0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = '0;
  logic        bit_ready, word_ready;
  logic [7:0]  health_evt;

  int checks = 0;
  int errors = 0;
  int n7, n5, n3, n2, nother;
  int pos5, pos3, nbits;
  logic [7:0] last_evt;

  always #10 clk = ~clk;

  bitstream_health_mon i_bitstream_health_mon (
    .clk(clk), .rst_n(rst_n), .en(en),
    .bit_valid(bit_valid), .bit_ready(bit_ready), .bit_data(bit_data),
    .word_valid(word_valid), .word_ready(word_ready), .word_data(word_data),
    .health_evt(health_evt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tally();
    last_evt = health_evt;
    if (health_evt[7]) n7++;
    if (health_evt[5]) begin n5++; pos5 = nbits; end
    if (health_evt[3]) begin n3++; pos3 = nbits; end
    if (health_evt[2]) n2++;
    if ((health_evt & 8'h53) != 0) nother++;
  endtask

  task automatic clear_tally();
    n7 = 0; n5 = 0; n3 = 0; n2 = 0; pos5 = -1; pos3 = -1; nbits = 0;
  endtask

  task automatic send_bit(input logic b);
    bit_valid = 1'b1; bit_data = b;
    @(negedge clk);
    nbits++;
    tally();
    bit_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tally();
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    word_valid = 1'b1; word_data = w;
    @(negedge clk);
    tally();
    word_valid = 1'b0;
  endtask

  task automatic reenable();
    en = 1'b0;
    idle(2);
    en = 1'b1;
  endtask

  task automatic t_reset();
    chk(health_evt == 8'h00, "R1 evt after reset", health_evt, 0);
    chk(bit_ready == 1'b0 && word_ready == 1'b0, "R1 ready with en low", bit_ready, 0);
    en = 1'b1;
    @(negedge clk);
    chk(bit_ready == 1'b1 && word_ready == 1'b1, "R1 ready with en high", word_ready, 1);
  endtask

  // one window holding exactly k ones
  task automatic t_window(input int k, input bit exp_fail, input string req);
    clear_tally();
    for (int i = 0; i < WIN; i++) begin
      logic b;
      if (k < WIN / 2) b = (i < 2 * k) ? logic'(i % 2) : 1'b0;
      else             b = (i < 2 * (WIN - k)) ? logic'(i % 2) : 1'b1;
      send_bit(b);
    end
    chk(n7 == int'(exp_fail), req, n7, int'(exp_fail));
    chk(last_evt[7] == exp_fail, {req, " on last bit"}, last_evt[7], exp_fail);
  endtask

  task automatic t_runs();
    reenable();
    clear_tally();
    for (int i = 0; i < 60; i++) send_bit(1'b1);
    chk(n5 == 1 && pos5 == 34, "R4 long run at 34th bit", pos5, 34);
    chk(n3 == 1 && pos3 == 48, "R5 noise run at 48th bit", pos3, 48);
    clear_tally();
    for (int i = 0; i < 33; i++) send_bit(1'b0);
    send_bit(1'b1);
    for (int i = 0; i < 33; i++) send_bit(1'b0);
    chk(n5 == 0, "R6 run restarts on change", n5, 0);
    clear_tally();
    send_bit(1'b1);
    for (int i = 0; i < 34; i++) send_bit(1'b0);
    chk(n5 == 1 && pos5 == 35, "R6 fresh run reaches 34", pos5, 35);
  endtask

  task automatic t_gap();
    reenable();
    clear_tally();
    for (int i = 0; i < 20; i++) send_bit(1'b1);
    bit_data = 1'b0;
    idle(5);
    chk(n5 == 0 && n3 == 0, "R9 quiet during gap", n5, 0);
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    chk(n5 == 1 && pos5 == 34, "R9 run held across gap", pos5, 34);
  endtask

  task automatic t_disable();
    reenable();
    clear_tally();
    for (int i = 0; i < 20; i++) send_bit(1'b1);
    en = 1'b0;
    bit_valid = 1'b1; bit_data = 1'b1;
    idle(40);
    bit_valid = 1'b0;
    chk(n5 == 0 && n3 == 0 && n7 == 0, "R11 no event while disabled", n5, 0);
    en = 1'b1;
    clear_tally();
    for (int i = 0; i < 20; i++) send_bit(1'b1);
    chk(n5 == 0, "R11 run cleared by disable", n5, 0);
    for (int i = 0; i < 14; i++) send_bit(1'b1);
    chk(n5 == 1 && pos5 == 34, "R11 run counts from enable", pos5, 34);
  endtask

  task automatic t_stuck();
    reenable();
    clear_tally();
    send_word(32'h0000_0000);
    chk(n2 == 0, "R8 first word not compared", n2, 0);
    send_word(32'h0000_0000);
    chk(last_evt[2] == 1'b1, "R7 repeated word", last_evt[2], 1);
    send_word(32'hA5A5_0001);
    chk(last_evt[2] == 1'b0, "R7 distinct word", last_evt[2], 0);
    send_word(32'hA5A5_0001);
    chk(last_evt[2] == 1'b1, "R7 second repeat", last_evt[2], 1);
    reenable();
    send_word(32'hA5A5_0001);
    chk(last_evt[2] == 1'b0, "R8 first word after enable", last_evt[2], 0);
    send_word(32'hA5A5_0001);
    chk(last_evt[2] == 1'b1, "R7 repeat after enable", last_evt[2], 1);
  endtask

  initial begin
    nother = 0;
    clear_tally();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window(10000, 1'b0, "R2 balanced window passes");
    t_window(9654, 1'b1, "R2 low bound fails");
    t_window(9655, 1'b0, "R3 next window just inside low");
    t_window(10345, 1'b0, "R3 window just inside high");
    t_window(10346, 1'b1, "R2 high bound fails");
    t_runs();
    t_gap();
    t_disable();
    t_stuck();
    chk(nother == 0, "R10 unused bits low", nother, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule